// File: doc/BRIEF.md
# Nonvolatile Store Sequencer

This block decides whether a channel value that the serial front end has just received should be committed to nonvolatile storage. It then runs the erase/write interval for that commit. The front end reports two events: a pulse when a frame's start bit arrives, and a pulse with the channel address and data when the last data bit lands. The host requests a commit by raising a program strobe inside a narrow window. The strobe must rise after the start bit and must be high at the first clock edge after the frame's last bit. If the strobe meets that window, the block pulls its active-low ready line low. It holds it low for a minimum, parameterised number of clock cycles, and for as long as the strobe stays high. When the interval ends, it fires one write strobe into the storage array.

A value that is not programmed is kept for only two clocks after reception and is then dropped. While busy, and during those two clocks, the block asks the front end to ignore serial traffic. A supply-low flag vetoes the commit. In that case ready stays high and nothing is written, so the host sees the failure as a missing busy pulse. The high-voltage ramp itself is outside this block.

Top module: `nvstore_seq`

## Requirements
- R1: After reset, `rdy` is 1, `nv_we` is 0 and `ser_block` is 0.
- R2: A commit is accepted only if `prog` has a rising edge after the edge that registered `frm_start`, and `prog` is 1 at the edge following the edge that registered `frm_done`. A rise in that decision edge itself counts. A strobe that was already high before the frame, or that rises only after the decision edge, is refused. On acceptance, `rdy` reads 0 from the decision edge on.
- R3: Once accepted, `rdy` stays 0 for at least `WR_CYC`+1 cycles. It returns to 1 at the first edge after that minimum at which `prog` is sampled 0.
- R4: At the edge where `rdy` returns to 1, `nv_we` is 1 for exactly one cycle. At that moment `nv_addr` and `nv_wdata` carry the address and data of the accepted frame.
- R5: While `rdy` is 0, `ser_block` is 1, and `frm_start`/`frm_done` pulses are ignored: they do not change the value that gets written.
- R6: Without an accepted commit, `ser_block` is 1 for the two cycles after the `frm_done` edge and 0 from the next edge on. No `nv_we` results.
- R7: If `lv_flag` is 1 at the decision edge, `rdy` stays 1 and no `nv_we` is issued, even when the strobe timing is valid.
- R8: `frm_start` and `frm_done` pulses are ignored while `cs` is 0.
- R9: `nv_addr` and `nv_wdata` do not change while `rdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; also times the write interval |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| prog | input | 1 | Program strobe from the host |
| frm_start | input | 1 | One-cycle pulse: start bit received |
| frm_done | input | 1 | One-cycle pulse: last data bit received |
| frm_addr | input | AW | Channel address of the finished frame |
| frm_data | input | DW | Channel value of the finished frame |
| lv_flag | input | 1 | Supply too low for programming |
| rdy | output | 1 | Ready (1) / busy (0) |
| nv_we | output | 1 | One-cycle write strobe to the storage array |
| nv_addr | output | AW | Channel address to write |
| nv_wdata | output | DW | Channel value to write |
| ser_block | output | 1 | Front end must ignore serial traffic |

## Verification
Take T as the edge that registers `frm_done`. Then `ser_block` is due one edge later, the accept/refuse decision shows on `rdy` after edge T+1, and the discard shows as `ser_block` low after edge T+2. The busy length is counted from edge T+1. It is the larger of `WR_CYC`+1 and one more than the cycle index at which the bench drops `prog`; `nv_we` must be seen in the same cycle that `rdy` is first seen high. The bench changes inputs on falling edges and samples on falling edges, so each result is read half a cycle after the rising edge the count above names. For refused frames, the bench also watches a few further cycles for a stray busy or write.

// File: rtl/nvstore_seq.sv
module nvstore_seq #(
  parameter int AW     = 2,
  parameter int DW     = 8,
  parameter int WR_CYC = 750000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          prog,
  input  logic          frm_start,
  input  logic          frm_done,
  input  logic [AW-1:0] frm_addr,
  input  logic [DW-1:0] frm_data,
  input  logic          lv_flag,
  output logic          rdy,
  output logic          nv_we,
  output logic [AW-1:0] nv_addr,
  output logic [DW-1:0] nv_wdata,
  output logic          ser_block
);
  localparam int CW = $clog2(WR_CYC + 1);
  localparam logic [CW-1:0] CNT_END = CW'(WR_CYC);

  logic          prog_q, in_frame, armed, held, aged, busy;
  logic [CW-1:0] cnt;

  wire rise     = prog & ~prog_q;
  wire start_ok = cs & frm_start & ~busy & ~held;
  wire done_ok  = cs & frm_done & ~busy & ~held & in_frame;
  wire decide   = held & ~busy & ~aged;
  wire want     = decide & prog & (armed | rise);
  wire accept   = want & ~lv_flag;
  wire finish   = busy & (cnt == CNT_END) & ~prog;

  assign rdy       = ~busy;
  assign ser_block = busy | held;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prog_q <= 1'b0;
    else        prog_q <= prog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      armed    <= 1'b0;
    end else if (start_ok) begin
      in_frame <= 1'b1;
      armed    <= 1'b0;
    end else if (decide) begin
      in_frame <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (!cs && !held) in_frame <= 1'b0;
      if (rise && in_frame) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= 1'b0;
      aged     <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      nv_we    <= 1'b0;
      nv_addr  <= '0;
      nv_wdata <= '0;
    end else begin
      nv_we <= 1'b0;
      if (done_ok) begin
        held     <= 1'b1;
        aged     <= 1'b0;
        nv_addr  <= frm_addr;
        nv_wdata <= frm_data;
      end else if (decide) begin
        if (accept) begin
          busy <= 1'b1;
          cnt  <= '0;
        end else begin
          aged <= 1'b1;
        end
      end else if (held && !busy && aged) begin
        held <= 1'b0;
      end else if (busy) begin
        if (cnt != CNT_END) cnt <= cnt + 1'b1;
        else if (finish) begin
          busy  <= 1'b0;
          held  <= 1'b0;
          nv_we <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nvstore_seq_chk.sv
module nvstore_seq_chk #(
  parameter int AW     = 2,
  parameter int DW     = 8,
  parameter int WR_CYC = 750000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prog,
  input logic          lv_flag,
  input logic          rdy,
  input logic          nv_we,
  input logic [AW-1:0] nv_addr,
  input logic [DW-1:0] nv_wdata,
  input logic          ser_block
);
  localparam int LW = $clog2(WR_CYC + 2);
  localparam logic [LW-1:0] LOW_SAT = LW'(WR_CYC + 1);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            low_cnt <= '0;
    else if (rdy)          low_cnt <= '0;
    else if (low_cnt != LOW_SAT) low_cnt <= low_cnt + 1'b1;

  a_r2_busy_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(prog));
  a_r7_no_busy_on_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> !$past(lv_flag));
  a_r3_min_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> (low_cnt == LOW_SAT));
  a_r3_release_after_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> !$past(prog));
  a_r4_write_only_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |-> $rose(rdy));
  a_r4_release_writes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> nv_we);
  a_r5_block_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> ser_block);
  a_r9_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && $past(!rdy)) |-> ($stable(nv_addr) && $stable(nv_wdata)));
endmodule

bind nvstore_seq nvstore_seq_chk #(.AW(AW), .DW(DW), .WR_CYC(WR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog(prog), .lv_flag(lv_flag), .rdy(rdy),
  .nv_we(nv_we), .nv_addr(nv_addr), .nv_wdata(nv_wdata), .ser_block(ser_block)
);

// File: tb/sim_nvstore_seq.sv
`timescale 1ns/1ps
module sim_nvstore_seq;
  localparam int AW = 2, DW = 8, W = 12;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b1, prog = 1'b0;
  logic frm_start = 1'b0, frm_done = 1'b0, lv_flag = 1'b0;
  logic [AW-1:0] frm_addr = '0;
  logic [DW-1:0] frm_data = '0;
  logic rdy, nv_we, ser_block;
  logic [AW-1:0] nv_addr;
  logic [DW-1:0] nv_wdata;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nvstore_seq #(.AW(AW), .DW(DW), .WR_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .prog(prog), .frm_start(frm_start),
    .frm_done(frm_done), .frm_addr(frm_addr), .frm_data(frm_data),
    .lv_flag(lv_flag), .rdy(rdy), .nv_we(nv_we), .nv_addr(nv_addr),
    .nv_wdata(nv_wdata), .ser_block(ser_block)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_accept(input int mode, input bit lv);
    return (mode == 2 || mode == 3) && !lv;
  endfunction

  function automatic int exp_len(input int hold);
    return (hold + 1 > W + 1) ? hold + 1 : W + 1;
  endfunction

  // mode 0: no strobe, 1: strobe high before start, 2: rises inside frame,
  // 3: rises at decision edge, 4: rises after decision edge
  task automatic trial(input int mode, input bit lv, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input int hold, input bit inject);
    bit acc;
    int i;
    bit early_we;
    acc = exp_accept(mode, lv);
    lv_flag = lv;
    if (mode == 1) begin prog = 1'b1; @(negedge clk); end
    frm_start = 1'b1;
    @(negedge clk);
    frm_start = 1'b0;
    if (mode == 2) prog = 1'b1;
    @(negedge clk);
    frm_done = 1'b1; frm_addr = a; frm_data = d;
    @(negedge clk);
    frm_done = 1'b0;
    chk("R6 block after frame", ser_block, 1);
    if (mode == 3) prog = 1'b1;
    @(negedge clk);
    chk(lv ? "R7 ready on low supply" : "R2 accept decision", rdy, acc ? 0 : 1);
    if (acc) begin
      i = 0;
      early_we = 1'b0;
      while (i < 400) begin
        if (i == hold) prog = 1'b0;
        frm_done  = inject && (i == 2);
        frm_start = inject && (i == 1);
        frm_addr  = ~a;
        frm_data  = ~d;
        if (nv_we) early_we = 1'b1;
        if (!ser_block) chk("R5 block while busy", ser_block, 1);
        @(negedge clk);
        i++;
        if (rdy) break;
      end
      frm_done = 1'b0; frm_start = 1'b0;
      chk("R3 busy length", i, exp_len(hold));
      chk("R4 early write", early_we, 0);
      chk("R4 write strobe", nv_we, 1);
      chk("R4 address", nv_addr, a);
      chk(inject ? "R5 data after ignored frame" : "R4 data", nv_wdata, d);
      @(negedge clk);
      chk("R4 single pulse", nv_we, 0);
    end else begin
      if (mode == 4) prog = 1'b1;
      chk("R6 block second cycle", ser_block, 1);
      @(negedge clk);
      chk("R6 dropped after two", ser_block, 0);
      for (int k = 0; k < 4; k++) begin
        if (!rdy || nv_we) begin
          chk(lv ? "R7 no busy" : "R6 no busy", rdy, 1);
          chk(lv ? "R7 no write" : "R6 no write", nv_we, 0);
        end
        @(negedge clk);
      end
      chk(lv ? "R7 still ready" : "R2 refused stays ready", rdy, 1);
    end
    prog = 1'b0; lv_flag = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 rdy", rdy, 1);
    chk("R1 nv_we", nv_we, 0);
    chk("R1 ser_block", ser_block, 0);
    rst_n = 1'b1;
    @(negedge clk);

    trial(2, 1'b0, 2'd1, 8'hA5, 0, 1'b0);
    trial(3, 1'b0, 2'd3, 8'h3C, W + 6, 1'b0);
    trial(2, 1'b0, 2'd0, 8'hFF, W, 1'b1);
    trial(1, 1'b0, 2'd2, 8'h11, 0, 1'b0);
    trial(4, 1'b0, 2'd2, 8'h22, 0, 1'b0);
    trial(0, 1'b0, 2'd1, 8'h33, 0, 1'b0);
    trial(2, 1'b1, 2'd1, 8'h44, 0, 1'b0);
    trial(3, 1'b1, 2'd0, 8'h55, 0, 1'b0);

    cs = 1'b0;
    prog = 1'b1;
    frm_start = 1'b1; @(negedge clk); frm_start = 1'b0;
    frm_done = 1'b1; frm_addr = 2'd3; frm_data = 8'h77; @(negedge clk);
    frm_done = 1'b0;
    chk("R8 no block when deselected", ser_block, 0);
    @(negedge clk);
    chk("R8 no busy when deselected", rdy, 1);
    chk("R8 no write when deselected", nv_we, 0);
    prog = 1'b0; cs = 1'b1;
    @(negedge clk);

    for (int t = 0; t < 60; t++) begin
      trial(int'($urandom_range(0, 4)), ($urandom_range(0, 5) == 0),
            AW'($urandom), DW'($urandom), int'($urandom_range(0, 2 * W)),
            $urandom_range(0, 1) == 1);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule